// File: doc/BRIEF.md
# Encoder Velocity Capture Timer

This block measures how fast an encoder is turning. It counts decoded encoder count pulses during a time window of programmable length. A down-counting window timer starts from a load value. When the timer reaches zero, the window closes. The number of pulses seen in that window is then latched into a capture register, and the live pulse counter starts again. A timer event marks each capture.

One cycle after each capture, the latched value is compared with a threshold. A second event flags a capture that is strictly below that threshold, which is the usual "shaft too slow or stalled" alarm. Software turns the captured count into a rotational speed. It uses the clock rate, the window length (load + 1 cycles), the encoder line count and the decode multiplier (2 or 4 pulses per line). That conversion is not part of this block.

A synchronous clear command restarts the measurement at any time. The live timer value, the live pulse count and the captured value each have their own output port.

Top module: `enc_vel_capture`

## Requirements
- R1: After a clear with load value L, `timer_now` reads L−1, L−2, … 0 on the following cycles. The cycle after it reads 0, the timer reloads, so consecutive `tmr_evt` pulses are exactly L+1 cycles apart.
- R2: The edge that sees `timer_now` equal to 0 does two things. It copies the live pulse count into `vel_cap`, and it raises `tmr_evt` for exactly one cycle, in the same cycle that `vel_cap` shows the new value. At all other times `vel_cap` holds its value.
- R3: One cycle after `tmr_evt`, `below_evt` is 1 for one cycle if `vel_cap` is strictly less than `cmp_val`. If `vel_cap` is equal to or above `cmp_val`, `below_evt` stays 0. `below_evt` is never 1 unless `tmr_evt` was 1 in the previous cycle.
- R4: `pulse_now` shows the running pulse count of the open window: it rises by one on each edge at which `pulse_in` is 1.
- R5: An edge with `vel_clear` = 1 does all of the following, whatever else is asserted in that cycle:
  - loads the timer from `load_val`;
  - sets `pulse_now` and `vel_cap` to 0;
  - sets both events to 0;
  - ignores any pulse present in that cycle.
- R6: A pulse sampled on the capture edge is not included in the capture. It counts as the first pulse of the new window, so `pulse_now` reads 1 after that edge.
- R7: The pulse counter stops at its all-ones value (255 with the default 8-bit width) and does not wrap. A window with more pulses captures the all-ones value.
- R8: While `rst` is high, every output reads 0.
- R9: A new `load_val` does not change the window that is already running. It is used only at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 1 | One decoded encoder count, sampled each edge |
| load_val | input | TIMER_W | Window reload value; window length is load_val+1 cycles |
| cmp_val | input | COUNT_W | Low-speed threshold for captured count |
| vel_clear | input | 1 | Synchronous measurement restart |
| timer_now | output | TIMER_W | Live window timer value |
| pulse_now | output | COUNT_W | Live pulse count of the open window |
| vel_cap | output | COUNT_W | Pulse count latched at the last window end |
| tmr_evt | output | 1 | One-cycle pulse when a capture has taken place |
| below_evt | output | 1 | One-cycle pulse when the capture is below cmp_val |

## Verification
The assertions assume that `pulse_in` is already a clean pulse, one cycle long per decoded count, and that no glitch or level reaches it. They also assume that `load_val` is stable whenever a reload can happen; a change shows up only at the next reload. The stimulus keeps to these assumptions in the following ways:
- It changes every input just after a rising edge.
- It sends pulses as single-cycle levels chosen per edge.
- It moves `load_val` only in the middle of a window.
- It begins every scenario with a clear, so each window starts from a known timer and count.

// File: rtl/evc_pkg.sv
package evc_pkg;

    // Control strobes derived once per cycle in the top and fanned out.
    typedef struct packed {
        logic restart;   // window closes this edge
        logic clear;     // measurement restart command
    } evc_ctrl_t;

    // Registered event outputs.
    typedef struct packed {
        logic tmr;
        logic below;
    } evc_evt_t;

endpackage

// File: rtl/evc_window_timer.sv
module evc_window_timer #(
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic [TIMER_W-1:0] load_val,
    output logic [TIMER_W-1:0] timer_q,
    output logic               expire
);

    localparam logic [TIMER_W-1:0] T_ZERO = '0;

    assign expire = (timer_q == T_ZERO);

    always_ff @(posedge clk) begin
        if (rst)
            timer_q <= T_ZERO;
        else if (clear || expire)
            timer_q <= load_val;
        else
            timer_q <= timer_q - 1'b1;
    end

    AST_TIMER_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
        (!expire && !clear) |=> (timer_q == TIMER_W'($past(timer_q) - 1'b1))); // R1

    AST_TIMER_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (expire || clear) |=> (timer_q == $past(load_val))); // R9

endmodule

// File: rtl/evc_pulse_counter.sv
module evc_pulse_counter
    import evc_pkg::*;
#(
    parameter int COUNT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  evc_ctrl_t          ctrl,
    input  logic               pulse,
    output logic [COUNT_W-1:0] cnt_q
);

    localparam logic [COUNT_W-1:0] C_MAX  = '1;
    localparam logic [COUNT_W-1:0] C_ZERO = '0;

    logic at_max;
    assign at_max = (cnt_q == C_MAX);

    always_ff @(posedge clk) begin
        if (rst || ctrl.clear)
            cnt_q <= C_ZERO;
        else if (ctrl.restart)
            cnt_q <= {{(COUNT_W-1){1'b0}}, pulse};
        else if (pulse && !at_max)
            cnt_q <= cnt_q + 1'b1;
    end

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (at_max && !ctrl.restart && !ctrl.clear) |=> (cnt_q == C_MAX)); // R7

    AST_CNT_NEW_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (ctrl.restart && !ctrl.clear) |=> (cnt_q == {{(COUNT_W-1){1'b0}}, $past(pulse)})); // R6

    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (rst)
        ctrl.clear |=> (cnt_q == C_ZERO)); // R5

endmodule

// File: rtl/evc_capture_cmp.sv
module evc_capture_cmp
    import evc_pkg::*;
#(
    parameter int COUNT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  evc_ctrl_t          ctrl,
    input  logic [COUNT_W-1:0] cnt,
    input  logic [COUNT_W-1:0] cmp_val,
    output logic [COUNT_W-1:0] cap_q,
    output evc_evt_t           evt_q
);

    logic take;
    assign take = ctrl.restart && !ctrl.clear;

    always_ff @(posedge clk) begin
        if (rst || ctrl.clear) begin
            cap_q <= '0;
            evt_q <= '0;
        end else begin
            if (take)
                cap_q <= cnt;
            evt_q.tmr   <= take;
            evt_q.below <= evt_q.tmr && (cap_q < cmp_val);
        end
    end

    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!take && !ctrl.clear) |=> $stable(cap_q)); // R2

    AST_BELOW_FOLLOWS_EVT: assert property (@(posedge clk) disable iff (rst)
        evt_q.below |-> $past(evt_q.tmr)); // R3

    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        !(evt_q.tmr && evt_q.below)); // R3

endmodule

// File: rtl/enc_vel_capture.sv
module enc_vel_capture
    import evc_pkg::*;
#(
    parameter int TIMER_W = 16,
    parameter int COUNT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pulse_in,
    input  logic [TIMER_W-1:0] load_val,
    input  logic [COUNT_W-1:0] cmp_val,
    input  logic               vel_clear,
    output logic [TIMER_W-1:0] timer_now,
    output logic [COUNT_W-1:0] pulse_now,
    output logic [COUNT_W-1:0] vel_cap,
    output logic               tmr_evt,
    output logic               below_evt
);

    evc_ctrl_t ctrl;
    evc_evt_t  evt;
    logic      expire;

    assign ctrl.restart = expire;
    assign ctrl.clear   = vel_clear;

    evc_window_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clear    (vel_clear),
        .load_val (load_val),
        .timer_q  (timer_now),
        .expire   (expire)
    );

    evc_pulse_counter #(.COUNT_W(COUNT_W)) u_count (
        .clk   (clk),
        .rst   (rst),
        .ctrl  (ctrl),
        .pulse (pulse_in),
        .cnt_q (pulse_now)
    );

    evc_capture_cmp #(.COUNT_W(COUNT_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl),
        .cnt     (pulse_now),
        .cmp_val (cmp_val),
        .cap_q   (vel_cap),
        .evt_q   (evt)
    );

    assign tmr_evt   = evt.tmr;
    assign below_evt = evt.below;

    AST_EVT_AT_RELOAD: assert property (@(posedge clk) disable iff (rst)
        tmr_evt |-> (timer_now == $past(load_val))); // R2

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (pulse_now == '0 && vel_cap == '0 && !tmr_evt && !below_evt)); // R8

endmodule

// File: tb/enc_vel_capture_test.sv
`timescale 1ns/1ps
module enc_vel_capture_test;

    localparam int TIMER_W = 16;
    localparam int COUNT_W = 8;
    localparam int CMAX    = (1 << COUNT_W) - 1;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               pulse_in = 1'b0;
    logic [TIMER_W-1:0] load_val = '0;
    logic [COUNT_W-1:0] cmp_val = '0;
    logic               vel_clear = 1'b0;
    logic [TIMER_W-1:0] timer_now;
    logic [COUNT_W-1:0] pulse_now;
    logic [COUNT_W-1:0] vel_cap;
    logic               tmr_evt;
    logic               below_evt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    enc_vel_capture #(.TIMER_W(TIMER_W), .COUNT_W(COUNT_W)) uut (
        .clk(clk), .rst(rst), .pulse_in(pulse_in), .load_val(load_val),
        .cmp_val(cmp_val), .vel_clear(vel_clear), .timer_now(timer_now),
        .pulse_now(pulse_now), .vel_cap(vel_cap), .tmr_evt(tmr_evt),
        .below_evt(below_evt)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic test_reset();
        step();
        step();
        chk("R8 timer", timer_now, 0);
        chk("R8 count", pulse_now, 0);
        chk("R8 cap", vel_cap, 0);
        chk("R8 tmr_evt", tmr_evt, 0);
        chk("R8 below_evt", below_evt, 0);
        rst = 1'b0;
    endtask

    // Clear (with a pulse that must be ignored), then run one full window
    // with a pulse on every edge k where k % m == 0 (m == 0: no pulses).
    task automatic run_window(input int l, input int m, input int cmp);
        int  exp_cnt = 0;
        int  sat = 0;
        logic p;
        cmp_val   = COUNT_W'(cmp);
        load_val  = TIMER_W'(l);
        pulse_in  = 1'b1;
        vel_clear = 1'b1;
        step();
        vel_clear = 1'b0;
        pulse_in  = 1'b0;
        chk("R5 timer", timer_now, l);
        chk("R5 count", pulse_now, 0);
        chk("R5 cap", vel_cap, 0);
        chk("R5 events", {tmr_evt, below_evt}, 0);
        for (int k = 1; k <= l + 1; k++) begin
            p = (m != 0) && (k % m == 0);
            pulse_in = p;
            step();
            if (k <= l) begin
                if (p) exp_cnt++;
                sat = (exp_cnt > CMAX) ? CMAX : exp_cnt;
                chk("R1 timer", timer_now, l - k);
                chk((exp_cnt > CMAX) ? "R7 saturate" : "R4 count", pulse_now, sat);
                chk("R1 no early evt", tmr_evt, 0);
            end else begin
                chk("R2 tmr_evt", tmr_evt, 1);
                chk("R2 capture", vel_cap, sat);
                chk("R1 reload", timer_now, l);
                chk("R6 new window", pulse_now, p ? 1 : 0);
            end
        end
        pulse_in = 1'b0;
        step();
        chk("R3 below", below_evt, (sat < cmp) ? 1 : 0);
        chk("R2 evt one cycle", tmr_evt, 0);
        chk("R2 cap held", vel_cap, sat);
    endtask

    task automatic test_load_change();
        cmp_val   = '0;
        load_val  = 16'd5;
        vel_clear = 1'b1;
        step();
        vel_clear = 1'b0;
        step();
        step();
        chk("R9 timer", timer_now, 3);
        load_val = 16'd3;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R9 old window", tmr_evt, 0);
        end
        chk("R9 reaches zero", timer_now, 0);
        step();
        chk("R9 evt", tmr_evt, 1);
        chk("R9 new load", timer_now, 3);
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R1 period", tmr_evt, 0);
        end
        step();
        chk("R1 second evt", tmr_evt, 1);
        chk("R1 reload again", timer_now, 3);
    endtask

    initial begin
        test_reset();
        run_window(9, 2, 4);     // 4 pulses, equal threshold: no event
        run_window(9, 2, 5);     // 4 < 5: event
        run_window(11, 3, 2);    // pulse on the capture edge
        run_window(6, 0, 1);     // stalled shaft
        run_window(300, 1, 255); // saturation
        test_load_change();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule